// File: doc/BRIEF.md
# Centre-Aligned Gate Pair Generator with Guard Interval

This block turns per-phase on-time commands into complementary upper and lower gate drives for a three-leg inverter. One period counter sets the time base for all legs. Each upper gate is switched on in a window of the commanded on-time, centred on the middle of the switching period. The matching lower gate is held off over a wider window, also centred. That window is widened by a programmable guard interval, so the slow turn-off of one switch cannot overlap the turn-on of the other in the same leg.

The period length, the three on-times and the guard interval are taken into shadow registers only when the counter wraps. A command may therefore be changed at any moment without tearing the running period. The guard value is meant to be set to about one and a half to twice the slowest switch turn-off time. Duty computation and sector selection sit upstream of this block.

Top module: `gate_pair_top`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it falls, every gate output is low; the first shadow load happens on that first edge.
- R2: The shared counter counts 0 up to the latched period minus one, then returns to 0. Period, on-times and guard are re-latched only on that return, so input changes inside a period have no effect until it ends.
- R3: With latched period T, on-time N and counter value c, the upper gate is high exactly when T−N ≤ 2c < T+N. This places its rising edge at (T−N)/2 and its falling edge at (T+N)/2.
- R4: With guard G, the lower gate is low exactly when T−N−G ≤ 2c < T+N+G, and high for the rest of the period.
- R5: When N+G ≥ T, the lower gate stays low for the whole period. When N = 0, the upper gate stays low for the whole period.
- R6: The upper and lower gates of one leg are never high in the same cycle.
- R7: Each gate output is registered: its value in a cycle reflects the counter value and latched settings of the cycle before.
- R8: The three legs share one counter and period, but each leg follows its own on-time. The on-time of leg k is bits [k*W +: W] of `on_time_in`.
- R9: The guard interval can be changed at run time, and the new value takes effect from the next counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_in | input | W | Switching period in clock cycles |
| on_time_in | input | NPH*W | Per-leg on-time, leg k at bits [k*W +: W] |
| guard_in | input | W | Extra lower-gate off time, split evenly about the centre |
| gate_hi | output | NPH | Upper switch drive per leg, high = on |
| gate_lo | output | NPH | Lower switch drive per leg, high = on |

## Verification
Two things can land on the same clock edge: the counter wrap that loads new settings, and a gate edge placed at count zero. This happens when the on-time equals or exceeds the period, or when the period is one or two cycles. The bench changes on-time and guard in the middle of a period, and runs periods of 1, 2 and odd lengths, so that the reload and the edges coincide. A behavioural model tracks every cycle and is compared with both gates of all legs on each clock. Overlap of the two gates in a leg is judged separately on every cycle.

// File: rtl/gate_pkg.sv
package gate_pkg;
  localparam int DEF_W   = 10;
  localparam int DEF_NPH = 3;

  // half-open window test on doubled positions
  function automatic logic in_win(input int pos2, input int lo, input int hi);
    return (pos2 >= lo) && (pos2 < hi);
  endfunction
endpackage

// File: rtl/period_timer.sv
module period_timer #(
  parameter int W   = gate_pkg::DEF_W,
  parameter int NPH = gate_pkg::DEF_NPH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   period_in,
  input  logic [NPH*W-1:0] on_time_in,
  input  logic [W-1:0]   guard_in,
  output logic [W-1:0]   cnt_o,
  output logic [W-1:0]   ts_o,
  output logic [NPH*W-1:0] ton_o,
  output logic [W-1:0]   dt_o,
  output logic           live_o
);
  localparam int CW = W + 1;

  logic [W-1:0]     cnt_q, ts_q, dt_q;
  logic [NPH*W-1:0] ton_q;
  logic             live_q;
  logic [CW-1:0]    cnt_nx;
  logic             wrap;

  always_comb begin
    cnt_nx = {1'b0, cnt_q} + CW'(1);
    wrap   = !live_q || (cnt_nx >= {1'b0, ts_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      ts_q   <= '0;
      dt_q   <= '0;
      ton_q  <= '0;
      live_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      ts_q   <= period_in;
      dt_q   <= guard_in;
      ton_q  <= on_time_in;
      live_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_nx[W-1:0];
    end
  end

  assign cnt_o  = cnt_q;
  assign ts_o   = ts_q;
  assign ton_o  = ton_q;
  assign dt_o   = dt_q;
  assign live_o = live_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && ts_q != '0) |-> (cnt_q < ts_q));
  // R2
  hold_mid_chk: assert property (@(posedge clk) disable iff (rst)
    (live_q && ({1'b0, cnt_q} + CW'(1) < {1'b0, ts_q})) |=>
      ($stable(ts_q) && $stable(ton_q) && $stable(dt_q)));
  // R1
  first_load_chk: assert property (@(posedge clk) disable iff (rst)
    !live_q |=> (live_q && cnt_q == '0));
endmodule

// File: rtl/leg_driver.sv
module leg_driver #(
  parameter int W = gate_pkg::DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] ts_i,
  input  logic [W-1:0] ton_i,
  input  logic [W-1:0] dt_i,
  input  logic         live_i,
  output logic         hi_o,
  output logic         lo_o
);
  import gate_pkg::*;

  int   pos2, t, n, g;
  logic hi_d, lo_d, hi_q, lo_q;

  always_comb begin
    pos2 = 2 * int'(cnt_i);
    t    = int'(ts_i);
    n    = int'(ton_i);
    g    = int'(dt_i);
    hi_d = live_i && (n != 0) && in_win(pos2, t - n, t + n);
    lo_d = live_i && ((n + g) < t) && !in_win(pos2, t - n - g, t + n + g);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(hi_q && lo_q));
  // R5
  upper_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (ton_i == '0) |=> !hi_q);
  // R5
  lower_block_chk: assert property (@(posedge clk) disable iff (rst)
    ((int'(ton_i) + int'(dt_i)) >= int'(ts_i)) |=> !lo_q);
  // R1
  unarmed_off_chk: assert property (@(posedge clk) disable iff (rst)
    !live_i |=> (!hi_q && !lo_q));
endmodule

// File: rtl/gate_pair_top.sv
module gate_pair_top #(
  parameter int W   = gate_pkg::DEF_W,
  parameter int NPH = gate_pkg::DEF_NPH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     period_in,
  input  logic [NPH*W-1:0] on_time_in,
  input  logic [W-1:0]     guard_in,
  output logic [NPH-1:0]   gate_hi,
  output logic [NPH-1:0]   gate_lo
);
  logic [W-1:0]     cnt, ts, dt;
  logic [NPH*W-1:0] ton;
  logic             live;

  period_timer #(.W(W), .NPH(NPH)) u_timer (
    .clk(clk), .rst(rst), .period_in(period_in), .on_time_in(on_time_in),
    .guard_in(guard_in), .cnt_o(cnt), .ts_o(ts), .ton_o(ton), .dt_o(dt),
    .live_o(live)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_leg
    leg_driver #(.W(W)) u_leg (
      .clk(clk), .rst(rst), .cnt_i(cnt), .ts_i(ts), .ton_i(ton[k*W +: W]),
      .dt_i(dt), .live_i(live), .hi_o(gate_hi[k]), .lo_o(gate_lo[k])
    );
  end
endmodule

// File: tb/gate_pair_top_test.sv
module gate_pair_top_test;
  localparam int W = 10;
  localparam int NPH = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] period_in = '0;
  logic [NPH*W-1:0] on_time_in = '0;
  logic [W-1:0] guard_in = '0;
  logic [NPH-1:0] gate_hi, gate_lo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gate_pair_top #(.W(W), .NPH(NPH)) uut (
    .clk(clk), .rst(rst), .period_in(period_in), .on_time_in(on_time_in),
    .guard_in(guard_in), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  // behavioural reference
  int m_cnt, m_ts, m_dt, m_live;
  int m_ton[NPH];
  bit exp_hi[NPH];
  bit exp_lo[NPH];
  bit exp_from_idle;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_ts = 0; m_dt = 0; m_live = 0;
      for (int k = 0; k < NPH; k++) begin
        m_ton[k] = 0; exp_hi[k] = 0; exp_lo[k] = 0;
      end
      exp_from_idle = 1;
    end else begin
      exp_from_idle = (m_live == 0);
      for (int k = 0; k < NPH; k++) begin
        int rise2, fall2, off_a, off_b;
        rise2 = m_ts - m_ton[k];
        fall2 = m_ts + m_ton[k];
        off_a = m_ts - m_ton[k] - m_dt;
        off_b = m_ts + m_ton[k] + m_dt;
        exp_hi[k] = (m_live != 0) && (m_ton[k] > 0) &&
                    (2*m_cnt >= rise2) && (2*m_cnt < fall2);
        exp_lo[k] = (m_live != 0) && (m_ton[k] + m_dt < m_ts) &&
                    !((2*m_cnt >= off_a) && (2*m_cnt < off_b));
      end
      if (m_live == 0 || m_cnt + 1 >= m_ts) begin
        m_cnt = 0; m_ts = int'(period_in); m_dt = int'(guard_in); m_live = 1;
        for (int k = 0; k < NPH; k++) m_ton[k] = int'(on_time_in[k*W +: W]);
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      for (int k = 0; k < NPH; k++) begin
        checks++;
        if (gate_hi[k] !== exp_hi[k]) begin
          errors++;
          $display("FAIL %s leg %0d upper: actual %b expected %b at %0t",
                   exp_from_idle ? "R1" : "R3", k, gate_hi[k], exp_hi[k], $time);
        end
        checks++;
        if (gate_lo[k] !== exp_lo[k]) begin
          errors++;
          $display("FAIL %s leg %0d lower: actual %b expected %b at %0t",
                   exp_from_idle ? "R1" : "R4", k, gate_lo[k], exp_lo[k], $time);
        end
        checks++;
        if (gate_hi[k] === 1'b1 && gate_lo[k] === 1'b1) begin
          errors++;
          $display("FAIL R6 leg %0d overlap: actual 11 expected not both high at %0t",
                   k, $time);
        end
      end
    end
  end

  task automatic apply(input int ts, input int a, input int b, input int c,
                       input int dt, input int ncyc);
    @(negedge clk);
    period_in  = W'(ts);
    on_time_in = {W'(c), W'(b), W'(a)};
    guard_in   = W'(dt);
    repeat (ncyc) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset holds all gates low, first load on first edge after release
    repeat (5) @(negedge clk);
    period_in = 10'd20; on_time_in = {10'd19, 10'd0, 10'd8}; guard_in = 10'd2;
    rst = 1'b0;
    // R3 R7 R8: three different on-times, zero on-time leg (R5)
    apply(20, 8, 0, 19, 2, 60);
    // R2: change mid period, no effect until wrap
    repeat (7) @(negedge clk);
    apply(20, 5, 12, 3, 2, 50);
    // R9 R5: larger guard blocks lower gate of leg with N+G >= T
    apply(20, 5, 12, 3, 8, 45);
    // R4: odd period, zero guard, on-time at and above period
    apply(21, 6, 21, 25, 0, 50);
    // tiny periods: wrap coincides with edges
    apply(1, 1, 0, 0, 0, 10);
    apply(2, 1, 0, 2, 0, 12);
    apply(3, 1, 2, 0, 1, 12);
    // R1: reset in the middle of running
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    period_in = 10'd16; on_time_in = {10'd15, 10'd8, 10'd4}; guard_in = 10'd1;
    rst = 1'b0;
    apply(16, 4, 8, 15, 1, 40);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule